// File: doc/BRIEF.md
# Bit-Addressable GPIO Port with Peripheral Override

This block is an eight-bit general-purpose I/O port. For each pin it holds one bit of an output latch and one bit of a direction register. A CPU-side bus reads and writes these registers. The bus also offers a single-cycle set/clear-bit access that changes exactly one latch bit. Any peripheral can take over a pin through its own per-bit enable. While it holds the pin, the peripheral decides the pin value and forces the pin to drive, whatever the latch and the direction bit say.

Pin levels pass through a two-flop synchroniser before anything uses them. The synchronised level serves three consumers: reads of the data register, the external-interrupt input vector and the peripheral input vector. The two input vectors only carry the level of pins that are really in input mode. The direction register is write-only.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 1 with no peripheral override makes the pin drive: `pin_oe` is 1 and `pin_out` equals the latch bit, one cycle after the register changes. A direction bit of 0 leaves `pin_oe` at 0.
- R2: A read (`bus_op`=0) of the data register (`bus_addr`=0) places a value on `bus_rdata` at the accepting clock edge. Bits whose direction bit is 1 show the latch. Bits whose direction bit is 0 show the synchronised pin level.
- R3: A set/clear-bit access (`bus_op`=2, `bus_addr`=0) writes `bus_bit_set` into latch bit `bus_bit_idx` in one cycle. It uses the latch as its source, so every other latch bit keeps its value whatever the pin levels are.
- R4: The direction register (`bus_addr`=1) is write-only. A read of that address returns all zeros, and a set/clear-bit access to it changes nothing.
- R5: When `periph_oe[i]` is 1, pin i drives (`pin_oe[i]`=1) with `periph_out[i]` one cycle later. The latch and direction bits for that pin are ignored.
- R6: `irq_in` and `periph_in` carry the synchronised pin level only for bits with direction 0 and no override, and 0 for every other bit. The latch has no effect on them.
- R7: Reset (synchronous, active high) clears the latch, the direction register (all inputs) and `bus_rdata`. `pin_oe`, `pin_out`, `irq_in` and `periph_in` read 0 on the cycle after reset.
- R8: A pin level change reaches `irq_in` and `periph_in` on the third rising edge after it is applied, and not before.
- R9: A write (`bus_op`=1) to the data register updates the latch whatever the direction is. The value appears on the pin once its direction bit becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_op | input | 2 | 0 read, 1 write, 2 set/clear bit, 3 idle |
| bus_addr | input | 1 | 0 data register, 1 direction register |
| bus_wdata | input | 8 | Write data |
| bus_bit_idx | input | 3 | Bit index for set/clear access |
| bus_bit_set | input | 1 | 1 sets, 0 clears the indexed bit |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| periph_oe | input | 8 | Per-pin peripheral override enables |
| periph_out | input | 8 | Peripheral output values |
| irq_in | output | 8 | Synchronised levels for the interrupt logic |
| periph_in | output | 8 | Synchronised levels for peripheral inputs |

## Verification
The hardest case to bring about is a set/clear-bit access whose result would differ if the pins were used as the source. The stimulus holds every pin high while all directions are inputs, loads a latch pattern that disagrees with the pins, then applies set and clear accesses. Afterwards all bits are switched to outputs so that the latch shows up directly on `pin_out`. A second hard case is an overridden pin whose latch and direction say the opposite. With the pins held high, the test checks that those bits leave both input vectors at zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BITOP = 2'd2,
    OP_IDLE  = 2'd3
  } gp_op_e;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            data_wr,
  input  logic            dir_wr,
  input  logic            bit_wr,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            bit_val,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    latch,
  output logic [W-1:0]    dir
);
  logic [W-1:0] bit_mask;
  logic [W-1:0] latch_nxt;

  always_comb begin
    bit_mask = '0;
    bit_mask[bit_idx] = 1'b1;
    latch_nxt = latch;
    if (data_wr)
      latch_nxt = wdata;
    else if (bit_wr)
      latch_nxt = bit_val ? (latch | bit_mask) : (latch & ~bit_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      dir   <= '0;
    end else begin
      latch <= latch_nxt;
      if (dir_wr) dir <= wdata;
    end
  end

  // R3: a bit access leaves every other latch bit untouched
  a_r3_other_bits_hold: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> (((latch ^ $past(latch)) & ~$past(bit_mask)) == '0));

  // R3: the indexed bit takes the requested value
  a_r3_indexed_bit: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> (latch[$past(bit_idx)] == $past(bit_val)));

  // R4: the direction register is only changed by a full write
  a_r4_dir_only_by_write: assert property (@(posedge clk) disable iff (rst)
    !dir_wr |=> $stable(dir));
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ovr_en,
  input  logic [W-1:0] ovr_val,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] irq_in,
  output logic [W-1:0] periph_in
);
  logic [W-1:0] out_nxt;
  logic [W-1:0] oe_nxt;
  logic [W-1:0] in_mode;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      oe_nxt[i]  = ovr_en[i] | dir[i];
      out_nxt[i] = ovr_en[i] ? ovr_val[i] : latch[i];
      in_mode[i] = ~ovr_en[i] & ~dir[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out   <= '0;
      pin_oe    <= '0;
      irq_in    <= '0;
      periph_in <= '0;
    end else begin
      pin_out   <= out_nxt;
      pin_oe    <= oe_nxt;
      irq_in    <= pin_sync & in_mode;
      periph_in <= pin_sync & in_mode;
    end
  end

  // R1: a plain output bit shows the latch value
  a_r1_latch_drives: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pin_out ^ $past(latch)) & $past(dir & ~ovr_en)) == '0));

  // R5: an overridden bit drives the peripheral value
  a_r5_override_wins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pin_oe & $past(ovr_en)) == $past(ovr_en)) &&
                     (((pin_out ^ $past(ovr_val)) & $past(ovr_en)) == '0)));

  // R6: a driving pin never feeds the input consumers
  a_r6_no_input_on_driver: assert property (@(posedge clk) disable iff (rst)
    ((irq_in | periph_in) & pin_oe) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDXW        = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_valid,
  input  logic [1:0]      bus_op,
  input  logic            bus_addr,
  input  logic [W-1:0]    bus_wdata,
  input  logic [IDXW-1:0] bus_bit_idx,
  input  logic            bus_bit_set,
  output logic [W-1:0]    bus_rdata,
  input  logic [W-1:0]    pin_in,
  output logic [W-1:0]    pin_out,
  output logic [W-1:0]    pin_oe,
  input  logic [W-1:0]    periph_oe,
  input  logic [W-1:0]    periph_out,
  output logic [W-1:0]    irq_in,
  output logic [W-1:0]    periph_in
);
  import gpio_pkg::*;

  gp_op_e       op;
  logic         rd_data, rd_dir, wr_data, wr_dir, bit_data;
  logic [W-1:0] latch, dir, pin_sync, rd_mux;

  always_comb begin
    op       = gp_op_e'(bus_op);
    rd_data  = bus_valid && op == OP_READ  && bus_addr == ADDR_DATA;
    rd_dir   = bus_valid && op == OP_READ  && bus_addr == ADDR_DIR;
    wr_data  = bus_valid && op == OP_WRITE && bus_addr == ADDR_DATA;
    wr_dir   = bus_valid && op == OP_WRITE && bus_addr == ADDR_DIR;
    bit_data = bus_valid && op == OP_BITOP && bus_addr == ADDR_DATA;
    rd_mux   = (latch & dir) | (pin_sync & ~dir);
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (pin_in), .q (pin_sync)
  );

  gpio_regs #(.W(W), .IDXW(IDXW)) u_regs (
    .clk (clk), .rst (rst), .data_wr (wr_data), .dir_wr (wr_dir),
    .bit_wr (bit_data), .bit_idx (bus_bit_idx), .bit_val (bus_bit_set),
    .wdata (bus_wdata), .latch (latch), .dir (dir)
  );

  gpio_pad #(.W(W)) u_pad (
    .clk (clk), .rst (rst), .latch (latch), .dir (dir),
    .ovr_en (periph_oe), .ovr_val (periph_out), .pin_sync (pin_sync),
    .pin_out (pin_out), .pin_oe (pin_oe), .irq_in (irq_in),
    .periph_in (periph_in)
  );

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (rd_data) bus_rdata <= rd_mux;
    else if (rd_dir)  bus_rdata <= '0;
  end

  // R4: the direction address reads back as zero
  a_r4_dir_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rd_dir |=> (bus_rdata == '0));

  // R7: reset leaves every output quiet
  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && irq_in == '0 && bus_rdata == '0));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0;
  logic [1:0] bus_op = 2'd3;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [2:0] bus_bit_idx = '0;
  logic       bus_bit_set = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, irq_in, periph_in;
  logic [7:0] periph_oe = '0;
  logic [7:0] periph_out = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_port uut (
    .clk (clk), .rst (rst), .bus_valid (bus_valid), .bus_op (bus_op),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_bit_idx (bus_bit_idx),
    .bus_bit_set (bus_bit_set), .bus_rdata (bus_rdata), .pin_in (pin_in),
    .pin_out (pin_out), .pin_oe (pin_oe), .periph_oe (periph_oe),
    .periph_out (periph_out), .irq_in (irq_in), .periph_in (periph_in)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(logic [1:0] op, logic addr, logic [7:0] wd,
                        logic [2:0] idx, logic setv);
    bus_valid = 1'b1; bus_op = op; bus_addr = addr;
    bus_wdata = wd; bus_bit_idx = idx; bus_bit_set = setv;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_op = 2'd3;
  endtask

  task automatic t_reset();
    pin_in = 8'hC3;
    rst = 1'b1;
    tick(3);
    chk("R7 pin_oe", pin_oe, 8'h00);
    chk("R7 pin_out", pin_out, 8'h00);
    chk("R7 rdata", bus_rdata, 8'h00);
    rst = 1'b0;
    tick(3);
    chk("R6 irq after reset", irq_in, 8'hC3);
    access(2'd0, 1'b0, 8'h00, 3'd0, 1'b0);
    chk("R2 input read", bus_rdata, 8'hC3);
    access(2'd1, 1'b1, 8'hFF, 3'd0, 1'b0);
    tick(1);
    chk("R7 latch cleared", pin_out, 8'h00);
    chk("R1 all outputs", pin_oe, 8'hFF);
  endtask

  task automatic t_direction();
    access(2'd1, 1'b0, 8'h3C, 3'd0, 1'b0);
    tick(1);
    chk("R1 pin_out", pin_out, 8'h3C);
    access(2'd1, 1'b1, 8'h0F, 3'd0, 1'b0);
    pin_in = 8'hA5;
    tick(3);
    chk("R1 partial oe", pin_oe, 8'h0F);
    access(2'd0, 1'b0, 8'h00, 3'd0, 1'b0);
    chk("R2 mixed read", bus_rdata, 8'hAC);
    chk("R6 irq mixed", irq_in, 8'hA0);
    chk("R6 periph mixed", periph_in, 8'hA0);
  endtask

  task automatic t_latch_hidden();
    access(2'd1, 1'b1, 8'h00, 3'd0, 1'b0);
    pin_in = 8'h00;
    access(2'd1, 1'b0, 8'h5A, 3'd0, 1'b0);
    tick(3);
    chk("R9 no drive while input", pin_oe, 8'h00);
    chk("R6 latch no effect", irq_in, 8'h00);
    access(2'd1, 1'b1, 8'hFF, 3'd0, 1'b0);
    tick(1);
    chk("R9 latch appears", pin_out, 8'h5A);
  endtask

  task automatic t_bitop();
    access(2'd1, 1'b1, 8'h00, 3'd0, 1'b0);
    pin_in = 8'hFF;
    tick(3);
    access(2'd2, 1'b0, 8'h00, 3'd0, 1'b1);
    access(2'd2, 1'b0, 8'h00, 3'd6, 1'b0);
    access(2'd1, 1'b1, 8'hFF, 3'd0, 1'b0);
    tick(1);
    chk("R3 set/clear from latch", pin_out, 8'h1B);
    access(2'd2, 1'b0, 8'h00, 3'd7, 1'b1);
    tick(1);
    chk("R3 single cycle set", pin_out, 8'h9B);
  endtask

  task automatic t_dir_wo();
    access(2'd1, 1'b1, 8'hF0, 3'd0, 1'b0);
    access(2'd0, 1'b1, 8'h00, 3'd0, 1'b0);
    chk("R4 dir read zero", bus_rdata, 8'h00);
    access(2'd2, 1'b1, 8'h00, 3'd0, 1'b1);
    tick(1);
    chk("R4 bitop ignored on dir", pin_oe, 8'hF0);
    chk("R4 bitop latch untouched", pin_out & 8'hF0, 8'h90);
  endtask

  task automatic t_override();
    access(2'd1, 1'b1, 8'h00, 3'd0, 1'b0);
    access(2'd1, 1'b0, 8'hFF, 3'd0, 1'b0);
    pin_in = 8'hFF;
    periph_oe = 8'h81;
    periph_out = 8'h01;
    tick(3);
    chk("R5 override oe", pin_oe, 8'h81);
    chk("R5 override value", pin_out & 8'h81, 8'h01);
    chk("R6 irq masked", irq_in, 8'h7E);
    chk("R6 periph masked", periph_in, 8'h7E);
    access(2'd1, 1'b1, 8'hFF, 3'd0, 1'b0);
    tick(1);
    chk("R5 override beats dir", pin_out & 8'h81, 8'h01);
    periph_oe = 8'h00;
    access(2'd1, 1'b1, 8'h00, 3'd0, 1'b0);
    tick(1);
  endtask

  task automatic t_sync();
    pin_in = 8'h00;
    tick(3);
    pin_in = 8'h0F;
    tick(2);
    chk("R8 not yet", irq_in, 8'h00);
    tick(1);
    chk("R8 third edge", irq_in, 8'h0F);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_direction();
    t_latch_hidden();
    t_bitop();
    t_dir_wo();
    t_override();
    t_sync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule